// File: doc/BRIEF.md
# PCI Target Bus Phase Tracker

This block watches the shared address/data lines of a PCI-style bus, together with the active-low frame, initiator-ready, target-ready and command/byte-enable lines. It splits every bus transaction into its single address phase and the data phases that follow. In the address phase it latches the 32-bit address and the 4-bit command and decodes the command into a transaction class. For each data phase that completes, it emits a one-cycle beat strobe that carries the active-high byte mask, the data with disabled lanes forced to zero, and the word address of that beat.

It is meant to sit in front of a target's decode and data-path logic. Address range matching, device-select timing, retry or abort signalling, parity and arbitration are not part of it. Every output is a register, so results appear one clock after the bus edge that produced them.

Top module: `pci_phase_tracker`

## Requirements
- R1: When the tracker is idle and `frame_n_i` is sampled low on a rising edge, that edge is the address phase. After that edge `busy_o`=1, `addr_q_o` holds `ad_i` and `cmd_q_o` holds the raw `cbe_n_i` value from that edge.
- R2: `class_o` decodes `cmd_q_o` as follows: 0000→1 (interrupt acknowledge), 0001→2 (special cycle), 0010→3 (I/O read), 0011→4 (I/O write), 0110→5 (memory read), 0111→6 (memory write), 1010→7 (configuration read), 1011→8 (configuration write), 1100→9 (memory read multiple), 1110→10 (memory read line), 1111→11 (memory write and invalidate). The reserved codes 0100, 0101, 1000, 1001 and 1101 map to 12.
- R3: A reserved command sets `unsupported_o`=1 for that transaction. No beat is produced for any of its data phases, and the transaction still ends normally.
- R4: On a beat, `beat_be_o` bit i = NOT `cbe_n_i[i]`, with bit 0 covering `ad_i[7:0]` and bit 3 covering `ad_i[31:24]`. `beat_data_o` equals `ad_i`, except that disabled lanes are forced to 0. When `beat_vld_o`=0, `beat_be_o`, `beat_data_o` and `beat_addr_o` are 0.
- R5: A data transfer happens only on an edge where the tracker is busy and both `irdy_n_i` and `trdy_n_i` are sampled low. `beat_vld_o` is 1 for exactly the cycle after such an edge. Ready activity while idle has no effect.
- R6: `addr_q_o` stays unchanged from the address phase until the transaction returns to idle.
- R7: A transfer with `frame_n_i` sampled high ends the transaction. After that edge `busy_o`=0, and `beat_last_o`=1 together with the beat. A new address phase may follow on the very next edge.
- R8: `beat_addr_o` = (address with bits [1:0] cleared) + 4·n modulo 2^32, where n is the number of transfers that came earlier in the same transaction.
- R9: A synchronous active-low reset clears every output to 0, including in the middle of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ad_i | input | 32 | Shared address/data lines |
| cbe_n_i | input | 4 | Command (address phase) or active-low byte enables (data phase) |
| frame_n_i | input | 1 | Frame, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| busy_o | output | 1 | Transaction in progress |
| addr_q_o | output | 32 | Latched transaction address |
| cmd_q_o | output | 4 | Latched raw command code |
| class_o | output | 4 | Decoded transaction class |
| unsupported_o | output | 1 | Latched command is reserved |
| beat_vld_o | output | 1 | One-cycle strobe per completed data phase |
| beat_last_o | output | 1 | Beat is the final one of its transaction |
| beat_be_o | output | 4 | Active-high byte-lane mask of the beat |
| beat_data_o | output | 32 | Beat data with disabled lanes zeroed |
| beat_addr_o | output | 32 | Word address of the beat |

## Verification
The assertions assume the bus follows the protocol. Frame is only deasserted in a data phase while the initiator is ready. The byte enables do not change between the wait states of one data phase. Ready signals may toggle freely while the bus is idle. The stimulus obeys these rules: frame is raised only on a final phase in a cycle where initiator-ready is low. The enables are chosen once per data phase. Wait states pull exactly one or both ready lines high, and the idle noise deliberately drives both ready lines low with frame high, to show that such activity is ignored.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

  typedef enum logic [3:0] {
    CLS_NONE        = 4'd0,
    CLS_INTACK      = 4'd1,
    CLS_SPECIAL     = 4'd2,
    CLS_IO_RD       = 4'd3,
    CLS_IO_WR       = 4'd4,
    CLS_MEM_RD      = 4'd5,
    CLS_MEM_WR      = 4'd6,
    CLS_CFG_RD      = 4'd7,
    CLS_CFG_WR      = 4'd8,
    CLS_MEM_RD_MULT = 4'd9,
    CLS_MEM_RD_LINE = 4'd10,
    CLS_MEM_WR_INV  = 4'd11,
    CLS_RESERVED    = 4'd12
  } txn_class_e;

  function automatic txn_class_e decode_cmd(input logic [3:0] code);
    case (code)
      4'b0000: return CLS_INTACK;
      4'b0001: return CLS_SPECIAL;
      4'b0010: return CLS_IO_RD;
      4'b0011: return CLS_IO_WR;
      4'b0110: return CLS_MEM_RD;
      4'b0111: return CLS_MEM_WR;
      4'b1010: return CLS_CFG_RD;
      4'b1011: return CLS_CFG_WR;
      4'b1100: return CLS_MEM_RD_MULT;
      4'b1110: return CLS_MEM_RD_LINE;
      4'b1111: return CLS_MEM_WR_INV;
      default: return CLS_RESERVED;
    endcase
  endfunction

  function automatic logic is_reserved(input txn_class_e cls);
    return cls == CLS_RESERVED;
  endfunction

endpackage

// File: rtl/ppt_phase_ctl.sv
module ppt_phase_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic trdy_n,
  output logic in_txn,
  output logic addr_evt,
  output logic xfer_evt,
  output logic end_evt
);

  logic in_txn_q;

  assign addr_evt = !in_txn_q && !frame_n;
  assign xfer_evt = in_txn_q && !irdy_n && !trdy_n;
  assign end_evt  = xfer_evt && frame_n;
  assign in_txn   = in_txn_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        in_txn_q <= 1'b0;
    else if (addr_evt) in_txn_q <= 1'b1;
    else if (end_evt)  in_txn_q <= 1'b0;
  end

endmodule

// File: rtl/ppt_cmd_dec.sv
module ppt_cmd_dec
  import ppt_pkg::*;
(
  input  logic [3:0]  cmd_code,
  output txn_class_e  cls,
  output logic        reserved
);

  assign cls      = decode_cmd(cmd_code);
  assign reserved = is_reserved(cls);

endmodule

// File: rtl/ppt_beat_path.sv
module ppt_beat_path
  import ppt_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_evt,
  input  logic              xfer_evt,
  input  logic              end_evt,
  input  logic [DATA_W-1:0] ad,
  input  logic [LANES-1:0]  cbe_n,
  input  txn_class_e        cls,
  input  logic              reserved,
  output logic [DATA_W-1:0] addr_q,
  output logic [LANES-1:0]  cmd_q,
  output txn_class_e        cls_q,
  output logic              unsup_q,
  output logic              beat_vld,
  output logic              beat_last,
  output logic [LANES-1:0]  beat_be,
  output logic [DATA_W-1:0] beat_data,
  output logic [DATA_W-1:0] beat_addr
);

  function automatic logic [DATA_W-1:0] align_word(input logic [DATA_W-1:0] a);
    return {a[DATA_W-1:2], 2'b00};
  endfunction

  function automatic logic [DATA_W-1:0] next_word(input logic [DATA_W-1:0] a);
    return a + DATA_W'(4);
  endfunction

  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] qual_data;
  logic              fire;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign qual_data[8*i +: 8] = cbe_n[i] ? 8'h00 : ad[8*i +: 8];
  end

  assign fire = xfer_evt && !unsup_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      cmd_q     <= '0;
      cls_q     <= CLS_NONE;
      unsup_q   <= 1'b0;
      word_q    <= '0;
      beat_vld  <= 1'b0;
      beat_last <= 1'b0;
      beat_be   <= '0;
      beat_data <= '0;
      beat_addr <= '0;
    end else begin
      beat_vld  <= fire;
      beat_last <= fire && end_evt;
      beat_be   <= fire ? ~cbe_n : '0;
      beat_data <= fire ? qual_data : '0;
      beat_addr <= fire ? word_q : '0;
      if (addr_evt) begin
        addr_q  <= ad;
        cmd_q   <= cbe_n;
        cls_q   <= cls;
        unsup_q <= reserved;
        word_q  <= align_word(ad);
      end else if (xfer_evt) begin
        word_q  <= next_word(word_q);
      end
    end
  end

endmodule

// File: rtl/pci_phase_tracker.sv
module pci_phase_tracker
  import ppt_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [LANES-1:0]  cbe_n_i,
  input  logic              frame_n_i,
  input  logic              irdy_n_i,
  input  logic              trdy_n_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] addr_q_o,
  output logic [LANES-1:0]  cmd_q_o,
  output logic [3:0]        class_o,
  output logic              unsupported_o,
  output logic              beat_vld_o,
  output logic              beat_last_o,
  output logic [LANES-1:0]  beat_be_o,
  output logic [DATA_W-1:0] beat_data_o,
  output logic [DATA_W-1:0] beat_addr_o
);

  logic       addr_evt;
  logic       xfer_evt;
  logic       end_evt;
  txn_class_e dec_cls;
  logic       dec_reserved;
  txn_class_e cls_q;

  ppt_phase_ctl u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n_i),
    .irdy_n   (irdy_n_i),
    .trdy_n   (trdy_n_i),
    .in_txn   (busy_o),
    .addr_evt (addr_evt),
    .xfer_evt (xfer_evt),
    .end_evt  (end_evt)
  );

  ppt_cmd_dec u_dec (
    .cmd_code (cbe_n_i[3:0]),
    .cls      (dec_cls),
    .reserved (dec_reserved)
  );

  ppt_beat_path #(.DATA_W(DATA_W)) u_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_evt  (addr_evt),
    .xfer_evt  (xfer_evt),
    .end_evt   (end_evt),
    .ad        (ad_i),
    .cbe_n     (cbe_n_i),
    .cls       (dec_cls),
    .reserved  (dec_reserved),
    .addr_q    (addr_q_o),
    .cmd_q     (cmd_q_o),
    .cls_q     (cls_q),
    .unsup_q   (unsupported_o),
    .beat_vld  (beat_vld_o),
    .beat_last (beat_last_o),
    .beat_be   (beat_be_o),
    .beat_data (beat_data_o),
    .beat_addr (beat_addr_o)
  );

  assign class_o = cls_q;

endmodule

// File: rtl/ppt_checker.sv
module ppt_checker #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irdy_n_i,
  input logic              trdy_n_i,
  input logic [DATA_W-1:0] ad_i,
  input logic              busy_o,
  input logic [DATA_W-1:0] addr_q_o,
  input logic              unsupported_o,
  input logic              beat_vld_o,
  input logic              beat_last_o,
  input logic [LANES-1:0]  beat_be_o,
  input logic [DATA_W-1:0] beat_data_o,
  input logic [DATA_W-1:0] beat_addr_o
);

  p_addr_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (addr_q_o == $past(ad_i)));

  p_no_beat_unsup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported_o |-> !beat_vld_o);

  p_idle_payload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_vld_o |-> (beat_be_o == '0 && beat_data_o == '0 && beat_addr_o == '0));

  p_beat_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld_o |-> $past(busy_o && !irdy_n_i && !trdy_n_i));

  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(addr_q_o));

  p_last_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |-> (beat_vld_o && !busy_o));

  p_word_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld_o && $past(beat_vld_o) && $past(busy_o))
      |-> (beat_addr_o == $past(beat_addr_o) + DATA_W'(4)));

endmodule

bind pci_phase_tracker ppt_checker #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .irdy_n_i      (irdy_n_i),
  .trdy_n_i      (trdy_n_i),
  .ad_i          (ad_i),
  .busy_o        (busy_o),
  .addr_q_o      (addr_q_o),
  .unsupported_o (unsupported_o),
  .beat_vld_o    (beat_vld_o),
  .beat_last_o   (beat_last_o),
  .beat_be_o     (beat_be_o),
  .beat_data_o   (beat_data_o),
  .beat_addr_o   (beat_addr_o)
);

// File: tb/tb_pci_phase_tracker.sv
`timescale 1ns/1ps
module tb_pci_phase_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic        busy, unsup, bvld, blast;
  logic [31:0] addr_q, bdata, baddr;
  logic [3:0]  cmd_q, cls, bbe;

  int total = 0, bad = 0, cyc = 0;
  bit chk_en = 0;

  always #2.5 clk = ~clk;

  pci_phase_tracker dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe_n),
    .frame_n_i(frame_n), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n),
    .busy_o(busy), .addr_q_o(addr_q), .cmd_q_o(cmd_q), .class_o(cls),
    .unsupported_o(unsup), .beat_vld_o(bvld), .beat_last_o(blast),
    .beat_be_o(bbe), .beat_data_o(bdata), .beat_addr_o(baddr));

  // reference model state
  bit          m_busy, m_uns, m_vld, m_last;
  logic [31:0] m_addr, m_data, m_baddr;
  logic [3:0]  m_cmd, m_cls, m_be;
  int          m_n;

  function automatic logic [3:0] ref_class(input logic [3:0] c);
    int t;
    t = 12;
    if (c == 4'h0) t = 1;
    if (c == 4'h1) t = 2;
    if (c == 4'h2) t = 3;
    if (c == 4'h3) t = 4;
    if (c == 4'h6) t = 5;
    if (c == 4'h7) t = 6;
    if (c == 4'hA) t = 7;
    if (c == 4'hB) t = 8;
    if (c == 4'hC) t = 9;
    if (c == 4'hE) t = 10;
    if (c == 4'hF) t = 11;
    return 4'(t);
  endfunction

  function automatic logic [31:0] ref_mask(input logic [31:0] d, input logic [3:0] en_n);
    logic [31:0] r;
    r = 0;
    for (int b = 0; b < 4; b++)
      if (!en_n[b]) r = r | (d & (32'hFF << (8 * b)));
    return r;
  endfunction

  always @(posedge clk) begin
    m_vld = 0; m_last = 0; m_be = 0; m_data = 0; m_baddr = 0;
    if (!rst_n) begin
      m_busy = 0; m_uns = 0; m_addr = 0; m_cmd = 0; m_cls = 0; m_n = 0;
    end else if (!m_busy) begin
      if (!frame_n) begin
        m_busy = 1; m_addr = ad; m_cmd = cbe_n; m_cls = ref_class(cbe_n);
        m_uns = (m_cls == 12); m_n = 0;
      end
    end else if (!irdy_n && !trdy_n) begin
      if (!m_uns) begin
        m_vld = 1; m_be = ~cbe_n; m_data = ref_mask(ad, cbe_n);
        m_baddr = 32'((m_addr / 4) * 4 + 4 * m_n);
        m_last = frame_n;
      end
      m_n++;
      if (frame_n) m_busy = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (chk_en) begin
    chk(busy == m_busy, "R1/R7 busy", 32'(busy), 32'(m_busy));
    chk(addr_q == m_addr, "R1/R6 addr", addr_q, m_addr);
    chk(cmd_q == m_cmd, "R1 cmd", 32'(cmd_q), 32'(m_cmd));
    chk(cls == m_cls, "R2 class", 32'(cls), 32'(m_cls));
    chk(unsup == m_uns, "R3 unsupported", 32'(unsup), 32'(m_uns));
    chk(bvld == m_vld, "R5 beat_vld", 32'(bvld), 32'(m_vld));
    chk(bbe == m_be, "R4 beat_be", 32'(bbe), 32'(m_be));
    chk(bdata == m_data, "R4 beat_data", bdata, m_data);
    chk(baddr == m_baddr, "R8 beat_addr", baddr, m_baddr);
    chk(blast == m_last, "R7 beat_last", 32'(blast), 32'(m_last));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog all-R actual=%0d expected<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n, input bit noisy);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_n = 1; ad = $urandom; cbe_n = 4'($urandom);
      irdy_n = noisy ? 1'b0 : 1'b1; trdy_n = noisy ? 1'b0 : 1'b1;
    end
  endtask

  task automatic txn(input logic [31:0] a, input logic [3:0] cmd, input int beats, input bit waits);
    logic [3:0] en;
    @(negedge clk);
    frame_n = 0; ad = a; cbe_n = cmd; irdy_n = 1; trdy_n = 1;
    for (int b = 0; b < beats; b++) begin
      en = 4'($urandom);
      if (waits) begin
        for (int w = 0; w < int'($urandom % 3); w++) begin
          @(negedge clk);
          cbe_n = en; ad = $urandom;
          irdy_n = 1'($urandom); trdy_n = 1'($urandom);
          if (!irdy_n && !trdy_n) trdy_n = 1;
          frame_n = (b == beats - 1 && !irdy_n) ? 1'b1 : 1'b0;
        end
      end
      @(negedge clk);
      cbe_n = en; ad = $urandom; irdy_n = 0; trdy_n = 0;
      frame_n = (b == beats - 1) ? 1'b1 : 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    chk_en = 1;
    @(negedge clk);
    // R9: reset state
    chk(busy == 0 && bvld == 0 && addr_q == 0 && cls == 0 && unsup == 0,
        "R9 reset state", {busy, bvld, unsup, cls, addr_q[25:0]}, 32'h0);
    rst_n = 1;
    // R5: ready activity while idle is ignored
    idle(4, 1);
    // R2/R3: every command code, with waits
    for (int c = 0; c < 16; c++) begin
      txn(32'h1000_0000 + 32'(c * 64), 4'(c), 1 + (c % 4), 1);
      idle(1, 0);
    end
    // R8: unaligned start and wrap past the top of the address space
    txn(32'h0000_1003, 4'h7, 3, 0);
    idle(1, 0);
    txn(32'hFFFF_FFF8, 4'h6, 4, 0);
    // R7: back-to-back transactions with no idle between
    txn(32'h2000_0010, 4'hF, 2, 0);
    txn(32'h3000_0020, 4'h4, 2, 1);
    txn(32'h4000_0030, 4'hB, 1, 0);
    idle(2, 1);
    // mixed random traffic
    for (int k = 0; k < 300; k++) begin
      txn($urandom, 4'($urandom), 1 + int'($urandom % 6), 1);
      idle(int'($urandom % 3), 1'($urandom));
    end
    // R9: reset in the middle of a transaction
    @(negedge clk);
    frame_n = 0; ad = 32'hABCD_0000; cbe_n = 4'h7; irdy_n = 1; trdy_n = 1;
    @(negedge clk);
    frame_n = 0; irdy_n = 0; trdy_n = 0; cbe_n = 4'h0;
    @(negedge clk);
    rst_n = 0; irdy_n = 1; trdy_n = 1;
    @(negedge clk);
    chk(busy == 0 && bvld == 0 && addr_q == 0 && cmd_q == 0 && bdata == 0,
        "R9 mid-transaction reset", {busy, bvld, cmd_q, addr_q[25:0]}, 32'h0);
    rst_n = 1; frame_n = 1;
    idle(3, 0);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule